// File: doc/BRIEF.md
# Bus Width and Select-Granularity Bridge

This block joins one Wishbone initiator port to one Wishbone subordinate port. The two sides may use different data widths, address widths and byte-select granularities. Either side may use the classic handshake or the pipelined one. Address, select, write data and read data are translated by combinational lane logic. A subordinate wider than the initiator sees the initiator's write data copied into every lane. The subordinate select bits are raised only on the lane that the dropped low address bits point at. Read data comes back from that same lane.

The handshake adapter has three variants, and the parameters choose one of them.

- **Same handshake on both sides:** acknowledge and stall are wired straight through.
- **Pipelined initiator, classic subordinate:** stall is produced from the pending request.
- **Classic initiator, pipelined subordinate:** a two-state machine issues each request to the subordinate only once.
  - **HS_IDLE:** the request strobe is forwarded. The machine moves to HS_WAIT when the subordinate accepts it (stall low) without acknowledging in the same cycle.
  - **HS_WAIT:** the strobe is withheld. The machine returns to HS_IDLE on acknowledge, or when the initiator drops cyc.

Optional signals that only one side carries are tied to safe values. Parameter sets that cannot be bridged stop elaboration with an error. These are:

- unequal total address space;
- a subordinate granularity coarser than the initiator's;
- an initiator wider than the subordinate;
- an initiator lock with no subordinate lock input;
- a subordinate err or rty with no initiator input for it.

Top module: `wb_width_bridge`

## Requirements
- R1: With identical port parameters and the same handshake style, the subordinate sees the initiator's address, we, cyc, stb and sel unchanged. Acknowledge and stall come back to the initiator in the same cycle.
- R2: The subordinate address equals the initiator address shifted right by log2(subordinate width / initiator width).
- R3: When the initiator granularity is coarser, each initiator select bit drives a group of (initiator granularity / subordinate granularity) subordinate select bits. A select of 0 gives all-zero subordinate selects.
- R4: The dropped low address bits pick a lane. Subordinate select bits outside that lane are 0. An 8-bit initiator at address 1 with sel 1 gives 0b0010. A 16-bit initiator at address 3 gives 0b1100.
- R5: The initiator write data is replicated into every lane of the subordinate write data (0xA5 gives 0xA5A5A5A5).
- R6: The initiator read data is the subordinate read lane picked by the low address bits. With subordinate data 0x03020100, an 8-bit initiator at address 1 reads 0x01, and a 16-bit initiator at address 3 reads 0x0302.
- R7: With a pipelined initiator and a classic subordinate, initiator stall is 1 while cyc and stb are 1 and no acknowledge is present. Stall is 0 in the cycle the subordinate acknowledges.
- R8: With a classic initiator and a pipelined subordinate, the strobe is forwarded in HS_IDLE. It is held low in HS_WAIT, which is entered after acceptance without acknowledge. HS_WAIT is left on acknowledge or on cyc low. Reset enters HS_IDLE.
- R9: Missing optional signals read as safe values:
  - initiator err and rty are 0 when the subordinate lacks them;
  - subordinate lock is 0 when the initiator lacks it;
  - the cycle-type output is always 3'b000 (classic);
  - the burst-type output is always 2'b00 (linear).
- R10: When both sides carry err, rty or lock, these pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the handshake state |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_adr | input | I_AW (11) | Initiator word address |
| i_dat_w | input | I_DW (16) | Initiator write data |
| i_dat_r | output | I_DW (16) | Read data returned to the initiator |
| i_sel | input | I_DW/I_GRAN (1) | Initiator select bits |
| i_cyc | input | 1 | Initiator cycle valid |
| i_stb | input | 1 | Initiator strobe |
| i_we | input | 1 | Initiator write enable |
| i_lock | input | 1 | Initiator lock request |
| i_ack | output | 1 | Acknowledge to the initiator |
| i_stall | output | 1 | Stall to a pipelined initiator |
| i_err | output | 1 | Error to the initiator |
| i_rty | output | 1 | Retry to the initiator |
| s_adr | output | S_AW (10) | Subordinate word address |
| s_dat_w | output | S_DW (32) | Subordinate write data |
| s_dat_r | input | S_DW (32) | Subordinate read data |
| s_sel | output | S_DW/S_GRAN (4) | Subordinate select bits |
| s_cyc | output | 1 | Subordinate cycle valid |
| s_stb | output | 1 | Subordinate strobe |
| s_we | output | 1 | Subordinate write enable |
| s_lock | output | 1 | Subordinate lock |
| s_cti | output | 3 | Cycle-type code |
| s_bte | output | 2 | Burst-type code |
| s_ack | input | 1 | Subordinate acknowledge |
| s_stall | input | 1 | Subordinate stall |
| s_err | input | 1 | Subordinate error |
| s_rty | input | 1 | Subordinate retry |

## Verification
The hardest case to reach is the HS_WAIT state of the classic-to-pipelined adapter, together with the two ways out of it. The state is only entered in a cycle where the subordinate drops stall while acknowledge stays low. The stimulus first holds stall high for several cycles, then releases it for one cycle with acknowledge low. Only after that does it present either an acknowledge or a cyc drop. A separate sequence gives acceptance and acknowledge in the same cycle, to show that HS_WAIT is skipped for a zero-wait subordinate. Four differently parameterised instances run side by side so that every lane, granularity and tie-off mapping is checked against known constants.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [0:0] {
        HS_IDLE = 1'b0,
        HS_WAIT = 1'b1
    } hs_state_e;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [1:0] BTE_LINEAR  = 2'b00;

endpackage

// File: rtl/wbb_sel_widen.sv
module wbb_sel_widen #(
    parameter int ISW = 1,
    parameter int EXP = 2
) (
    input  logic [ISW-1:0]     in_sel,
    output logic [ISW*EXP-1:0] out_sel
);

    for (genvar g = 0; g < ISW; g++) begin : g_bit
        assign out_sel[g*EXP +: EXP] = {EXP{in_sel[g]}};
    end

endmodule

// File: rtl/wbb_lane_map.sv
module wbb_lane_map #(
    parameter int I_AW = 11,
    parameter int I_DW = 16,
    parameter int S_AW = 10,
    parameter int S_DW = 32,
    parameter int IWS  = 2,
    parameter int SSW  = 4
) (
    input  logic [I_AW-1:0] i_adr,
    input  logic [I_DW-1:0] i_dat_w,
    input  logic [IWS-1:0]  wide_sel,
    input  logic [S_DW-1:0] s_dat_r,
    output logic [S_AW-1:0] s_adr,
    output logic [S_DW-1:0] s_dat_w,
    output logic [SSW-1:0]  s_sel,
    output logic [I_DW-1:0] i_dat_r
);

    localparam int RATIO = S_DW / I_DW;
    localparam int LSB   = $clog2(RATIO);
    localparam int LW    = (LSB > 0) ? LSB : 1;

    logic [LW-1:0] lane;

    assign lane    = (LSB > 0) ? i_adr[LW-1:0] : '0;
    assign s_adr   = S_AW'(i_adr >> LSB);
    assign s_dat_w = {RATIO{i_dat_w}};
    assign s_sel   = SSW'(SSW'(wide_sel) << (int'(lane) * IWS));
    assign i_dat_r = I_DW'(s_dat_r >> (int'(lane) * I_DW));

endmodule

// File: rtl/wbb_hs_adapt.sv
module wbb_hs_adapt
    import wbb_pkg::*;
#(
    parameter bit I_PIPE = 1'b0,
    parameter bit S_PIPE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i_cyc,
    input  logic i_stb,
    input  logic s_ack,
    input  logic s_stall,
    output logic s_stb,
    output logic i_ack,
    output logic i_stall
);

    if (!I_PIPE && S_PIPE) begin : g_cls2pipe
        hs_state_e state_q;
        hs_state_e state_d;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q <= HS_IDLE;
            end else begin
                state_q <= state_d;
            end
        end

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                HS_IDLE: begin
                    if (i_cyc && i_stb && !s_stall && !s_ack) begin
                        state_d = HS_WAIT;
                    end
                end
                HS_WAIT: begin
                    if (!i_cyc || s_ack) begin
                        state_d = HS_IDLE;
                    end
                end
                default: state_d = HS_IDLE;
            endcase
        end

        always_comb begin
            i_ack   = s_ack;
            i_stall = 1'b0;
            unique case (state_q)
                HS_IDLE: s_stb = i_cyc && i_stb;
                HS_WAIT: s_stb = 1'b0;
                default: s_stb = 1'b0;
            endcase
        end
    end else if (I_PIPE && !S_PIPE) begin : g_pipe2cls
        assign s_stb   = i_stb;
        assign i_ack   = s_ack;
        assign i_stall = i_cyc && i_stb && !s_ack;
    end else begin : g_same
        assign s_stb   = i_stb;
        assign i_ack   = s_ack;
        assign i_stall = I_PIPE ? s_stall : 1'b0;
    end

endmodule

// File: rtl/wb_width_bridge.sv
module wb_width_bridge
    import wbb_pkg::*;
#(
    parameter int I_AW       = 11,
    parameter int I_DW       = 16,
    parameter int I_GRAN     = 16,
    parameter int S_AW       = 10,
    parameter int S_DW       = 32,
    parameter int S_GRAN     = 8,
    parameter bit I_PIPE     = 1'b0,
    parameter bit S_PIPE     = 1'b1,
    parameter bit I_HAS_LOCK = 1'b1,
    parameter bit I_HAS_ERR  = 1'b1,
    parameter bit I_HAS_RTY  = 1'b1,
    parameter bit S_HAS_LOCK = 1'b1,
    parameter bit S_HAS_ERR  = 1'b1,
    parameter bit S_HAS_RTY  = 1'b1,
    localparam int ISW = I_DW / I_GRAN,
    localparam int SSW = S_DW / S_GRAN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [I_AW-1:0] i_adr,
    input  logic [I_DW-1:0] i_dat_w,
    output logic [I_DW-1:0] i_dat_r,
    input  logic [ISW-1:0]  i_sel,
    input  logic            i_cyc,
    input  logic            i_stb,
    input  logic            i_we,
    input  logic            i_lock,
    output logic            i_ack,
    output logic            i_stall,
    output logic            i_err,
    output logic            i_rty,
    output logic [S_AW-1:0] s_adr,
    output logic [S_DW-1:0] s_dat_w,
    input  logic [S_DW-1:0] s_dat_r,
    output logic [SSW-1:0]  s_sel,
    output logic            s_cyc,
    output logic            s_stb,
    output logic            s_we,
    output logic            s_lock,
    output logic [2:0]      s_cti,
    output logic [1:0]      s_bte,
    input  logic            s_ack,
    input  logic            s_stall,
    input  logic            s_err,
    input  logic            s_rty
);

    localparam int EXP   = I_GRAN / S_GRAN;
    localparam int IWS   = ISW * EXP;
    localparam int I_LOG = $clog2(I_DW);
    localparam int S_LOG = $clog2(S_DW);

    // Elaboration-time legality checks
    if (I_DW > S_DW) begin : g_bad_wider
        $error("initiator wider than subordinate needs multi-cycle split: unsupported");
    end
    if (I_AW + I_LOG != S_AW + S_LOG) begin : g_bad_space
        $error("address space of the two ports differs");
    end
    if (S_GRAN > I_GRAN) begin : g_bad_gran
        $error("subordinate granularity coarser than initiator granularity");
    end
    if (I_HAS_LOCK && !S_HAS_LOCK) begin : g_bad_lock
        $error("initiator lock has no subordinate input");
    end
    if (S_HAS_ERR && !I_HAS_ERR) begin : g_bad_err
        $error("subordinate err has no initiator input");
    end
    if (S_HAS_RTY && !I_HAS_RTY) begin : g_bad_rty
        $error("subordinate rty has no initiator input");
    end

    logic [IWS-1:0] wide_sel;

    wbb_sel_widen #(
        .ISW (ISW),
        .EXP (EXP)
    ) u_widen (
        .in_sel  (i_sel),
        .out_sel (wide_sel)
    );

    wbb_lane_map #(
        .I_AW (I_AW),
        .I_DW (I_DW),
        .S_AW (S_AW),
        .S_DW (S_DW),
        .IWS  (IWS),
        .SSW  (SSW)
    ) u_lanes (
        .i_adr    (i_adr),
        .i_dat_w  (i_dat_w),
        .wide_sel (wide_sel),
        .s_dat_r  (s_dat_r),
        .s_adr    (s_adr),
        .s_dat_w  (s_dat_w),
        .s_sel    (s_sel),
        .i_dat_r  (i_dat_r)
    );

    wbb_hs_adapt #(
        .I_PIPE (I_PIPE),
        .S_PIPE (S_PIPE)
    ) u_hs (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_cyc   (i_cyc),
        .i_stb   (i_stb),
        .s_ack   (s_ack),
        .s_stall (s_stall),
        .s_stb   (s_stb),
        .i_ack   (i_ack),
        .i_stall (i_stall)
    );

    assign s_cyc  = i_cyc;
    assign s_we   = i_we;
    assign s_lock = I_HAS_LOCK ? i_lock : 1'b0;
    assign i_err  = S_HAS_ERR ? s_err : 1'b0;
    assign i_rty  = S_HAS_RTY ? s_rty : 1'b0;
    assign s_cti  = CTI_CLASSIC;
    assign s_bte  = BTE_LINEAR;

endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
    parameter int I_AW   = 11,
    parameter int I_DW   = 16,
    parameter int I_GRAN = 16,
    parameter int S_AW   = 10,
    parameter int S_DW   = 32,
    parameter int S_GRAN = 8,
    parameter bit I_PIPE = 1'b0,
    parameter bit S_PIPE = 1'b1,
    localparam int ISW = I_DW / I_GRAN,
    localparam int SSW = S_DW / S_GRAN
) (
    input logic            clk,
    input logic            rst_n,
    input logic [I_AW-1:0] i_adr,
    input logic [ISW-1:0]  i_sel,
    input logic [I_DW-1:0] i_dat_r,
    input logic            i_cyc,
    input logic            i_stb,
    input logic            i_stall,
    input logic [S_AW-1:0] s_adr,
    input logic [S_DW-1:0] s_dat_w,
    input logic [S_DW-1:0] s_dat_r,
    input logic [SSW-1:0]  s_sel,
    input logic            s_stb,
    input logic            s_ack,
    input logic            s_stall
);

    localparam int RATIO = S_DW / I_DW;
    localparam int LSB   = $clog2(RATIO);
    localparam int LW    = (LSB > 0) ? LSB : 1;
    localparam int IWS   = I_DW / S_GRAN;

    logic [LW-1:0]  lane_c;
    logic [SSW-1:0] lane_mask;

    assign lane_c    = (LSB > 0) ? i_adr[LW-1:0] : '0;
    assign lane_mask = SSW'(SSW'({IWS{1'b1}}) << (int'(lane_c) * IWS));

    p_adr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(i_adr[I_AW-1:LSB]) |-> $stable(s_adr));

    p_sel_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_sel == '0) |-> (s_sel == '0));

    p_sel_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_sel & ~lane_mask) == '0));

    p_wdat_repl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_dat_w == {RATIO{s_dat_w[I_DW-1:0]}}));

    p_rdat_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(s_dat_r) && $stable(i_adr)) |-> $stable(i_dat_r));

    if (I_PIPE && !S_PIPE) begin : g_p2c
        p_stall_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (i_cyc && i_stb && !s_ack) |-> i_stall);
        p_stall_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
            s_ack |-> !i_stall);
    end

    if (!I_PIPE && S_PIPE) begin : g_c2p
        p_issue_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (s_stb && !s_stall && !s_ack) |=> !s_stb);
    end

endmodule

bind wb_width_bridge wbb_checker #(
    .I_AW   (I_AW),
    .I_DW   (I_DW),
    .I_GRAN (I_GRAN),
    .S_AW   (S_AW),
    .S_DW   (S_DW),
    .S_GRAN (S_GRAN),
    .I_PIPE (I_PIPE),
    .S_PIPE (S_PIPE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .i_adr   (i_adr),
    .i_sel   (i_sel),
    .i_dat_r (i_dat_r),
    .i_cyc   (i_cyc),
    .i_stb   (i_stb),
    .i_stall (i_stall),
    .s_adr   (s_adr),
    .s_dat_w (s_dat_w),
    .s_dat_r (s_dat_r),
    .s_sel   (s_sel),
    .s_stb   (s_stb),
    .s_ack   (s_ack),
    .s_stall (s_stall)
);

// File: tb/sim_wb_width_bridge.sv
module sim_wb_width_bridge;

    localparam int CYC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CYC/2) clk = ~clk;

    // shared stimulus, sliced per instance
    logic [11:0] b_adr  = '0;
    logic [31:0] b_dw   = '0;
    logic [3:0]  b_sel  = '0;
    logic        b_cyc  = 1'b0;
    logic        b_stb  = 1'b0;
    logic        b_we   = 1'b0;
    logic        b_lock = 1'b0;
    logic [31:0] b_sdr  = '0;
    logic        b_sack = 1'b0;
    logic        b_sstl = 1'b0;
    logic        b_serr = 1'b0;
    logic        b_srty = 1'b0;

    // u0: 16-bit classic initiator -> 32-bit byte-select pipelined subordinate
    logic [15:0] u0_idr;
    logic        u0_iack, u0_istl, u0_ierr, u0_irty;
    logic [9:0]  u0_sadr;
    logic [31:0] u0_sdw;
    logic [3:0]  u0_ssel;
    logic        u0_scyc, u0_sstb, u0_swe, u0_slock;
    logic [2:0]  u0_scti;
    logic [1:0]  u0_sbte;

    wb_width_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .i_adr(b_adr[10:0]), .i_dat_w(b_dw[15:0]), .i_dat_r(u0_idr), .i_sel(b_sel[0:0]),
        .i_cyc(b_cyc), .i_stb(b_stb), .i_we(b_we), .i_lock(b_lock),
        .i_ack(u0_iack), .i_stall(u0_istl), .i_err(u0_ierr), .i_rty(u0_irty),
        .s_adr(u0_sadr), .s_dat_w(u0_sdw), .s_dat_r(b_sdr), .s_sel(u0_ssel),
        .s_cyc(u0_scyc), .s_stb(u0_sstb), .s_we(u0_swe), .s_lock(u0_slock),
        .s_cti(u0_scti), .s_bte(u0_sbte),
        .s_ack(b_sack), .s_stall(b_sstl), .s_err(b_serr), .s_rty(b_srty)
    );

    // u1: 8-bit pipelined initiator -> 32-bit classic subordinate, tie-offs
    logic [7:0]  u1_idr;
    logic        u1_iack, u1_istl, u1_ierr, u1_irty;
    logic [9:0]  u1_sadr;
    logic [31:0] u1_sdw;
    logic [3:0]  u1_ssel;
    logic        u1_scyc, u1_sstb, u1_swe, u1_slock;
    logic [2:0]  u1_scti;
    logic [1:0]  u1_sbte;

    wb_width_bridge #(
        .I_AW(12), .I_DW(8), .I_GRAN(8), .S_AW(10), .S_DW(32), .S_GRAN(8),
        .I_PIPE(1'b1), .S_PIPE(1'b0),
        .I_HAS_LOCK(1'b0), .I_HAS_ERR(1'b1), .I_HAS_RTY(1'b1),
        .S_HAS_LOCK(1'b1), .S_HAS_ERR(1'b0), .S_HAS_RTY(1'b0)
    ) u1 (
        .clk(clk), .rst_n(rst_n),
        .i_adr(b_adr), .i_dat_w(b_dw[7:0]), .i_dat_r(u1_idr), .i_sel(b_sel[0:0]),
        .i_cyc(b_cyc), .i_stb(b_stb), .i_we(b_we), .i_lock(b_lock),
        .i_ack(u1_iack), .i_stall(u1_istl), .i_err(u1_ierr), .i_rty(u1_irty),
        .s_adr(u1_sadr), .s_dat_w(u1_sdw), .s_dat_r(b_sdr), .s_sel(u1_ssel),
        .s_cyc(u1_scyc), .s_stb(u1_sstb), .s_we(u1_swe), .s_lock(u1_slock),
        .s_cti(u1_scti), .s_bte(u1_sbte),
        .s_ack(b_sack), .s_stall(b_sstl), .s_err(b_serr), .s_rty(b_srty)
    );

    // u2: 32-bit word-granular initiator -> 32-bit byte-granular subordinate
    logic [31:0] u2_idr;
    logic        u2_iack, u2_istl, u2_ierr, u2_irty;
    logic [9:0]  u2_sadr;
    logic [31:0] u2_sdw;
    logic [3:0]  u2_ssel;
    logic        u2_scyc, u2_sstb, u2_swe, u2_slock;
    logic [2:0]  u2_scti;
    logic [1:0]  u2_sbte;

    wb_width_bridge #(
        .I_AW(10), .I_DW(32), .I_GRAN(32), .S_AW(10), .S_DW(32), .S_GRAN(8),
        .I_PIPE(1'b0), .S_PIPE(1'b0),
        .I_HAS_LOCK(1'b0), .I_HAS_ERR(1'b0), .I_HAS_RTY(1'b0),
        .S_HAS_LOCK(1'b0), .S_HAS_ERR(1'b0), .S_HAS_RTY(1'b0)
    ) u2 (
        .clk(clk), .rst_n(rst_n),
        .i_adr(b_adr[9:0]), .i_dat_w(b_dw), .i_dat_r(u2_idr), .i_sel(b_sel[0:0]),
        .i_cyc(b_cyc), .i_stb(b_stb), .i_we(b_we), .i_lock(b_lock),
        .i_ack(u2_iack), .i_stall(u2_istl), .i_err(u2_ierr), .i_rty(u2_irty),
        .s_adr(u2_sadr), .s_dat_w(u2_sdw), .s_dat_r(b_sdr), .s_sel(u2_ssel),
        .s_cyc(u2_scyc), .s_stb(u2_sstb), .s_we(u2_swe), .s_lock(u2_slock),
        .s_cti(u2_scti), .s_bte(u2_sbte),
        .s_ack(b_sack), .s_stall(b_sstl), .s_err(b_serr), .s_rty(b_srty)
    );

    // u3: identical 8-bit pipelined ports, all optional signals present
    logic [7:0]  u3_idr;
    logic        u3_iack, u3_istl, u3_ierr, u3_irty;
    logic [9:0]  u3_sadr;
    logic [7:0]  u3_sdw;
    logic [0:0]  u3_ssel;
    logic        u3_scyc, u3_sstb, u3_swe, u3_slock;
    logic [2:0]  u3_scti;
    logic [1:0]  u3_sbte;

    wb_width_bridge #(
        .I_AW(10), .I_DW(8), .I_GRAN(8), .S_AW(10), .S_DW(8), .S_GRAN(8),
        .I_PIPE(1'b1), .S_PIPE(1'b1)
    ) u3 (
        .clk(clk), .rst_n(rst_n),
        .i_adr(b_adr[9:0]), .i_dat_w(b_dw[7:0]), .i_dat_r(u3_idr), .i_sel(b_sel[0:0]),
        .i_cyc(b_cyc), .i_stb(b_stb), .i_we(b_we), .i_lock(b_lock),
        .i_ack(u3_iack), .i_stall(u3_istl), .i_err(u3_ierr), .i_rty(u3_irty),
        .s_adr(u3_sadr), .s_dat_w(u3_sdw), .s_dat_r(b_sdr[7:0]), .s_sel(u3_ssel),
        .s_cyc(u3_scyc), .s_stb(u3_sstb), .s_we(u3_swe), .s_lock(u3_slock),
        .s_cti(u3_scti), .s_bte(u3_sbte),
        .s_ack(b_sack), .s_stall(b_sstl), .s_err(b_serr), .s_rty(b_srty)
    );

    typedef enum int {
        U0_SADR, U0_SSEL, U0_SDW, U0_IDR, U0_SSTB, U0_IACK, U0_SCTI, U0_SBTE,
        U1_SADR, U1_SSEL, U1_SDW, U1_IDR, U1_ISTL, U1_IACK, U1_IERR, U1_IRTY,
        U1_SLOCK, U1_SCTI, U1_SBTE,
        U2_SSEL,
        U3_SADR, U3_SSEL, U3_SWE, U3_SCYC, U3_SSTB, U3_ISTL, U3_IACK, U3_IERR,
        U3_SLOCK
    } probe_e;

    typedef struct {
        probe_e      sig;
        string       req;
        logic [31:0] exp;
    } item_t;

    item_t exp_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    function automatic logic [31:0] probe(probe_e s);
        case (s)
            U0_SADR:  return 32'(u0_sadr);
            U0_SSEL:  return 32'(u0_ssel);
            U0_SDW:   return u0_sdw;
            U0_IDR:   return 32'(u0_idr);
            U0_SSTB:  return 32'(u0_sstb);
            U0_IACK:  return 32'(u0_iack);
            U0_SCTI:  return 32'(u0_scti);
            U0_SBTE:  return 32'(u0_sbte);
            U1_SADR:  return 32'(u1_sadr);
            U1_SSEL:  return 32'(u1_ssel);
            U1_SDW:   return u1_sdw;
            U1_IDR:   return 32'(u1_idr);
            U1_ISTL:  return 32'(u1_istl);
            U1_IACK:  return 32'(u1_iack);
            U1_IERR:  return 32'(u1_ierr);
            U1_IRTY:  return 32'(u1_irty);
            U1_SLOCK: return 32'(u1_slock);
            U1_SCTI:  return 32'(u1_scti);
            U1_SBTE:  return 32'(u1_sbte);
            U2_SSEL:  return 32'(u2_ssel);
            U3_SADR:  return 32'(u3_sadr);
            U3_SSEL:  return 32'(u3_ssel);
            U3_SWE:   return 32'(u3_swe);
            U3_SCYC:  return 32'(u3_scyc);
            U3_SSTB:  return 32'(u3_sstb);
            U3_ISTL:  return 32'(u3_istl);
            U3_IACK:  return 32'(u3_iack);
            U3_IERR:  return 32'(u3_ierr);
            U3_SLOCK: return 32'(u3_slock);
            default:  return 32'hDEAD_BEEF;
        endcase
    endfunction

    // driver side: push an expectation for the current cycle
    task automatic expect_item(probe_e s, string req, logic [31:0] v);
        item_t it;
        it.sig = s;
        it.req = req;
        it.exp = v;
        exp_q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        b_adr = '0; b_dw = '0; b_sel = '0; b_cyc = 1'b0; b_stb = 1'b0;
        b_we = 1'b0; b_lock = 1'b0; b_sdr = '0; b_sack = 1'b0;
        b_sstl = 1'b0; b_serr = 1'b0; b_srty = 1'b0;
    endtask

    task automatic do_reset();
        step();
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    // monitor: compare queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = probe(it.sig);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s %s: actual=0x%0h expected=0x%0h",
                             it.req, it.sig.name(), act, it.exp);
                end
            end
        end
    end

    initial begin
        #(CYC * 20000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();

        // reset state: u0 in HS_IDLE, no ack, fixed codes
        step();
        expect_item(U0_SSTB, "R8", 32'h0);
        expect_item(U0_IACK, "R8", 32'h0);
        expect_item(U0_SCTI, "R9", 32'h0);
        expect_item(U0_SBTE, "R9", 32'h0);

        // R1: identical parameters pass through (u3)
        do_reset();
        step();
        b_adr = 12'd1; b_we = 1'b0; b_cyc = 1'b1; b_stb = 1'b1; b_sel = 4'h1; b_sstl = 1'b1;
        expect_item(U3_SADR, "R1", 32'd1);
        expect_item(U3_SWE,  "R1", 32'd0);
        expect_item(U3_SCYC, "R1", 32'd1);
        expect_item(U3_SSTB, "R1", 32'd1);
        expect_item(U3_SSEL, "R1", 32'd1);
        expect_item(U3_ISTL, "R1", 32'd1);
        step();
        b_sstl = 1'b0;
        expect_item(U3_ISTL, "R1", 32'd0);
        step();
        b_sack = 1'b1;
        expect_item(U3_IACK, "R1", 32'd1);
        step();
        b_adr = 12'd127; b_we = 1'b1; b_stb = 1'b0; b_sel = 4'h0; b_sack = 1'b0;
        expect_item(U3_SADR, "R1", 32'd127);
        expect_item(U3_SWE,  "R1", 32'd1);
        expect_item(U3_SSTB, "R1", 32'd0);
        expect_item(U3_SSEL, "R1", 32'd0);

        // R2 address shift, R4 lanes, R5 replication, R6 read lane
        do_reset();
        step();
        b_adr = 12'd1; b_sel = 4'h1; b_dw = 32'h0000_A55A; b_sdr = 32'h0302_0100;
        expect_item(U1_SADR, "R2", 32'd0);
        expect_item(U0_SADR, "R2", 32'd0);
        expect_item(U1_SSEL, "R4", 32'b0010);
        expect_item(U0_SSEL, "R4", 32'b1100);
        expect_item(U1_SDW,  "R5", 32'h5A5A_5A5A);
        expect_item(U0_SDW,  "R5", 32'hA55A_A55A);
        expect_item(U1_IDR,  "R6", 32'h01);
        expect_item(U0_IDR,  "R6", 32'h0302);
        step();
        b_adr = 12'd3; b_dw = 32'h0000_00A5;
        expect_item(U1_SADR, "R2", 32'd0);
        expect_item(U0_SADR, "R2", 32'd1);
        expect_item(U1_SSEL, "R4", 32'b1000);
        expect_item(U0_SSEL, "R4", 32'b1100);
        expect_item(U1_SDW,  "R5", 32'hA5A5_A5A5);
        expect_item(U1_IDR,  "R6", 32'h03);
        expect_item(U0_IDR,  "R6", 32'h0302);
        step();
        b_adr = 12'hFFE; b_sdr = 32'hCAFE_F00D;
        expect_item(U1_SADR, "R2", 32'h3FF);
        expect_item(U0_SADR, "R2", 32'h3FF);
        expect_item(U1_SSEL, "R4", 32'b0100);
        expect_item(U0_SSEL, "R4", 32'b0011);
        expect_item(U1_IDR,  "R6", 32'hFE);
        expect_item(U0_IDR,  "R6", 32'hF00D);
        step();
        b_sel = 4'h0;
        expect_item(U1_SSEL, "R4", 32'b0000);
        expect_item(U0_SSEL, "R4", 32'b0000);

        // R3 granularity expansion (u2)
        step();
        b_adr = 12'd5; b_sel = 4'h1;
        expect_item(U2_SSEL, "R3", 32'b1111);
        step();
        b_sel = 4'h0;
        expect_item(U2_SSEL, "R3", 32'b0000);

        // R7 pipelined initiator, classic subordinate (u1)
        do_reset();
        step();
        b_cyc = 1'b1; b_stb = 1'b1;
        expect_item(U1_ISTL, "R7", 32'd1);
        expect_item(U1_IACK, "R7", 32'd0);
        step();
        expect_item(U1_ISTL, "R7", 32'd1);
        step();
        b_sack = 1'b1;
        expect_item(U1_ISTL, "R7", 32'd0);
        expect_item(U1_IACK, "R7", 32'd1);
        step();
        b_stb = 1'b0; b_sack = 1'b0;
        expect_item(U1_ISTL, "R7", 32'd0);

        // R8 classic initiator, pipelined subordinate (u0): stalled issue
        do_reset();
        step();
        b_cyc = 1'b1; b_stb = 1'b1; b_sstl = 1'b1;
        expect_item(U0_SSTB, "R8", 32'd1);
        step();
        expect_item(U0_SSTB, "R8", 32'd1);
        step();
        b_sstl = 1'b0;
        expect_item(U0_SSTB, "R8", 32'd1);
        step();
        expect_item(U0_SSTB, "R8", 32'd0);
        expect_item(U0_IACK, "R8", 32'd0);
        step();
        expect_item(U0_SSTB, "R8", 32'd0);
        step();
        b_sack = 1'b1;
        expect_item(U0_SSTB, "R8", 32'd0);
        expect_item(U0_IACK, "R8", 32'd1);
        step();
        b_cyc = 1'b0; b_stb = 1'b0; b_sack = 1'b0;
        expect_item(U0_SSTB, "R8", 32'd0);
        expect_item(U0_IACK, "R8", 32'd0);
        // zero-wait subordinate: acceptance and ack together skip HS_WAIT
        step();
        b_cyc = 1'b1; b_stb = 1'b1; b_sack = 1'b1;
        expect_item(U0_SSTB, "R8", 32'd1);
        expect_item(U0_IACK, "R8", 32'd1);
        step();
        b_sack = 1'b0; b_sstl = 1'b1;
        expect_item(U0_SSTB, "R8", 32'd1);
        // leave HS_WAIT by dropping cyc
        step();
        b_sstl = 1'b0;
        expect_item(U0_SSTB, "R8", 32'd1);
        step();
        expect_item(U0_SSTB, "R8", 32'd0);
        b_cyc = 1'b0; b_stb = 1'b0;
        step();
        b_cyc = 1'b1; b_stb = 1'b1; b_sstl = 1'b1;
        expect_item(U0_SSTB, "R8", 32'd1);

        // R9 tie-offs (u1), R10 pass-through of optional signals (u3)
        do_reset();
        step();
        b_serr = 1'b1; b_srty = 1'b1; b_lock = 1'b1;
        expect_item(U1_IERR,  "R9", 32'd0);
        expect_item(U1_IRTY,  "R9", 32'd0);
        expect_item(U1_SLOCK, "R9", 32'd0);
        expect_item(U1_SCTI,  "R9", 32'd0);
        expect_item(U1_SBTE,  "R9", 32'd0);
        expect_item(U3_IERR,  "R10", 32'd1);
        expect_item(U3_SLOCK, "R10", 32'd1);
        step();
        b_serr = 1'b0; b_lock = 1'b0;
        expect_item(U3_IERR,  "R10", 32'd0);
        expect_item(U3_SLOCK, "R10", 32'd0);

        @(negedge clk);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule